// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a register-programmed SPI master for serial flash parts. Software first loads a 24-bit address register and a 32-bit data register. It then writes a command word, and that write starts a frame. A frame shifts out an opcode byte, then up to three address bytes, then up to fifteen dummy bytes, and ends with up to four data bytes that are either sent from the data register or captured into it. Each command word carries its own phase lengths, so a long flash transaction can be split into several command words.

Each command word also carries a keep-selected flag. When the flag is set, chip select stays asserted after the frame. The next command then shares that assertion: its opcode is not sent again and only its non-empty phases are shifted. Software can therefore stream any number of 4-byte data chunks behind one opcode and address. A status register shows a pending bit while a frame runs. It also shows a sticky error bit, which is set when a command is written while a frame is still pending. The serial clock follows SPI mode 3, and its period and both edge positions are programmed in system clock cycles.

Top module: `sflash_seq`

## Requirements
- R1: After reset, status reads 0, every `cs_n` line is high, `sck` is high, the timing register reads 0x0000_0204 and the address and data registers read 0.
- R2: Writing word offset 3 while no frame is pending starts a frame. Command fields: opcode [7:0], write-direction [8], data count [11:9], keep-selected [15], dummy count [19:16], address count [22:20], chip select [26:24]. If chip select is not already held, the first byte sent is the opcode. Every byte is sent most significant bit first.
- R3: The address phase sends A bytes taken from the address register, where A is the address count with values above 3 treated as 3. It sends byte A-1 first and byte 0 last, so with A=3 bits 23:16 go first.
- R4: The dummy phase sends as many bytes as the dummy count, 0 to 15, with MOSI low. Anything received during these bytes leaves the data register unchanged.
- R5: When the write-direction bit is 1, the data phase sends N bytes, where N is the data count with values above 4 treated as 4. Bits 7:0 of the data register go first, then bits 15:8, and so on. The data register is not changed.
- R6: When the write-direction bit is 0, the data phase drives MOSI low for N bytes. Received byte k is stored in data register bits 8k+7:8k, and the other bytes of the register keep their values.
- R7: Status bit 22 (pending) reads 1 from the cycle after a frame starts until its last bit is done.
- R8: A command written while pending is set starts nothing and sets status bit 29 (error). Writing status with bit 29 = 1 clears the error bit, and writing it with bit 29 = 0 leaves the error bit set.
- R9: With keep-selected = 1, chip select stays asserted after the frame. A following command does not resend the opcode, and its chip-select field is ignored.
- R10: With keep-selected = 0, chip select is released at the end of the frame. A command with all counts zero, written while chip select is held, sends no clock edges and only releases chip select.
- R11: `sck` idles high. Each bit lasts P cycles, where P is the period field [3:0] and values below 2 are treated as 2. `sck` falls F cycles and rises R cycles into the bit, where F is timing [15:12] and R is timing [11:8]; software keeps F < R < P. MOSI changes at the fall and MISO is sampled at the rise, and bits follow each other without gaps.
- R12: Chip-select field value i drives `cs_n[i]` low. A value of NCS or more asserts no line, and the frame still runs.
- R13: The register offsets are 0 for timing, 1 for address (reads back 24 bits), 2 for data, 3 for command (reads 0) and 4 for status. `bus_rdata` shows the register selected by `bus_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| cs_n | output | NCS | Active-low chip selects |

## Verification
A wrong phase counter or byte selector shows up on MOSI within the frame where it happens. It appears as a changed bit count, a missing or resent opcode, or an address byte in the wrong order. A fault in the receive path or the byte index shows up at the next read of the data register after the frame: the wrong byte lane is filled, or a dummy byte leaks into the register. Chip-select and pending state errors can be seen at `cs_n` and in the status word in the first cycles after a frame ends. A fault in the edge counter changes the measured spacing of `sck` edges in the very first bit.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DUM, PH_DATA} phase_e;

  // register word offsets
  localparam int REG_TIME = 0;
  localparam int REG_ADDR = 1;
  localparam int REG_DATA = 2;
  localparam int REG_CMD  = 3;
  localparam int REG_STAT = 4;

  // command word fields
  localparam int CMD_WR_BIT   = 8;
  localparam int CMD_CNT_LSB  = 9;
  localparam int CMD_KEEP_BIT = 15;
  localparam int CMD_DUM_LSB  = 16;
  localparam int CMD_ALEN_LSB = 20;
  localparam int CMD_CS_LSB   = 24;

  // status bits
  localparam int ST_PEND_BIT = 22;
  localparam int ST_ERR_BIT  = 29;

  // timing register reset: period 4, rise at 2, fall at 0
  localparam logic [15:0] TIME_RESET = 16'h0204;
endpackage

// File: rtl/sfq_clkgen.sv
module sfq_clkgen #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] per,
  input  logic [CW-1:0] rpos,
  input  logic [CW-1:0] fpos,
  output logic          sck,
  output logic          fall_tick,
  output logic          rise_tick,
  output logic          bit_end
);
  localparam logic [CW-1:0] MIN_PER = 2;
  localparam logic [CW-1:0] ONE     = 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last      = (per < MIN_PER) ? (MIN_PER - ONE) : (per - ONE);
  assign fall_tick = run && (cnt == fpos);
  assign rise_tick = run && (cnt == rpos);
  assign bit_end   = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else begin
      cnt <= bit_end ? '0 : cnt + ONE;
      if (fall_tick)      sck <= 1'b0;
      else if (rise_tick) sck <= 1'b1;
    end
  end

  // R11: the serial clock is high whenever no frame runs
  p_sck_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> sck);
endmodule

// File: rtl/sfq_shift.sv
module sfq_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         fall_tick,
  input  logic         rise_tick,
  input  logic         bit_end,
  input  logic         miso,
  output logic         mosi,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);
  localparam logic [BW-1:0] ONE      = 1;

  logic [W-1:0]  sh;
  logic [W-1:0]  rx;
  logic [BW-1:0] bitn;

  assign byte_done = bit_end && (bitn == LAST_BIT);
  assign rx_byte   = rise_tick ? {rx[W-2:0], miso} : rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      rx   <= '0;
      bitn <= '0;
      mosi <= 1'b0;
    end else begin
      if (fall_tick) mosi <= sh[W-1];
      if (load)           sh <= load_byte;
      else if (fall_tick) sh <= {sh[W-2:0], 1'b0};
      if (rise_tick) rx <= {rx[W-2:0], miso};
      if (load)         bitn <= '0;
      else if (bit_end) bitn <= bitn + ONE;
    end
  end
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfq_pkg::*;
#(
  parameter int NCS = 2,
  parameter int AW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic [NCS-1:0] cs_n
);
  localparam int ADW   = 24;
  localparam int TW    = 4;
  localparam int CSF_W = 3;

  logic [15:0]    tm_q;
  logic [ADW-1:0] addr_q;
  logic [31:0]    data_q;
  logic           err_q, busy, cs_held, dir_q, keep_q;
  logic [1:0]     a_rem, k_q;
  logic [3:0]     d_rem;
  logic [2:0]     n_rem;
  phase_e         cur_ph;

  logic fall_tick, rise_tick, bit_end, byte_done;
  logic [7:0] rx_byte;

  // command field decode (with clamping of counts)
  logic             cmd_wr, start, take;
  logic [1:0]       f_alen;
  logic [2:0]       f_cnt;
  logic [3:0]       f_dum;
  logic             f_dir, f_keep;
  logic [CSF_W-1:0] f_cs;
  logic [NCS-1:0]   cs_dec;

  assign cmd_wr = bus_we && (bus_addr == AW'(REG_CMD));
  assign start  = cmd_wr && !busy;
  assign f_alen = (bus_wdata[CMD_ALEN_LSB +: 3] > 3'd3) ? 2'd3 : bus_wdata[CMD_ALEN_LSB +: 2];
  assign f_cnt  = (bus_wdata[CMD_CNT_LSB +: 3] > 3'd4) ? 3'd4 : bus_wdata[CMD_CNT_LSB +: 3];
  assign f_dum  = bus_wdata[CMD_DUM_LSB +: 4];
  assign f_dir  = bus_wdata[CMD_WR_BIT];
  assign f_keep = bus_wdata[CMD_KEEP_BIT];
  assign f_cs   = bus_wdata[CMD_CS_LSB +: CSF_W];

  for (genvar g = 0; g < NCS; g++) begin : g_csdec
    assign cs_dec[g] = (f_cs != CSF_W'(g));
  end

  // next-byte picker: phases in fixed order op, address, dummy, data
  logic       s_op, s_wr;
  logic [1:0] s_a, s_k;
  logic [3:0] s_d;
  logic [2:0] s_n;
  logic       pick_v;
  phase_e     pick_ph;
  logic [7:0] pick_b;

  always_comb begin
    if (start) begin
      s_op = !cs_held;  s_a = f_alen;  s_d = f_dum;  s_n = f_cnt;
      s_k  = 2'd0;      s_wr = f_dir;
    end else begin
      s_op = 1'b0;      s_a = a_rem;   s_d = d_rem;  s_n = n_rem;
      s_k  = (cur_ph == PH_DATA) ? k_q + 2'd1 : k_q;
      s_wr = dir_q;
    end
    pick_v  = 1'b1;
    pick_ph = PH_OP;
    pick_b  = bus_wdata[7:0];
    if (s_op) begin
      pick_ph = PH_OP;
    end else if (s_a != 2'd0) begin
      pick_ph = PH_ADDR;
      pick_b  = addr_q[{s_a - 2'd1, 3'b000} +: 8];
    end else if (s_d != 4'd0) begin
      pick_ph = PH_DUM;
      pick_b  = 8'h00;
    end else if (s_n != 3'd0) begin
      pick_ph = PH_DATA;
      pick_b  = s_wr ? data_q[{s_k, 3'b000} +: 8] : 8'h00;
    end else begin
      pick_v  = 1'b0;
    end
  end

  assign take = start || byte_done;

  sfq_clkgen #(.CW(TW)) u_clk (
    .clk, .rst, .run(busy),
    .per(tm_q[3:0]), .rpos(tm_q[11:8]), .fpos(tm_q[15:12]),
    .sck, .fall_tick, .rise_tick, .bit_end
  );

  sfq_shift #(.W(8)) u_sh (
    .clk, .rst, .load(take && pick_v), .load_byte(pick_b),
    .fall_tick, .rise_tick, .bit_end, .miso,
    .mosi, .byte_done, .rx_byte
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q    <= TIME_RESET;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      busy    <= 1'b0;
      cs_held <= 1'b0;
      cs_n    <= '1;
      dir_q   <= 1'b0;
      keep_q  <= 1'b0;
      a_rem   <= '0;
      d_rem   <= '0;
      n_rem   <= '0;
      k_q     <= '0;
      cur_ph  <= PH_OP;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          AW'(REG_TIME): tm_q   <= bus_wdata[15:0];
          AW'(REG_ADDR): addr_q <= bus_wdata[ADW-1:0];
          AW'(REG_DATA): data_q <= bus_wdata;
          AW'(REG_STAT): if (bus_wdata[ST_ERR_BIT]) err_q <= 1'b0;
          default: ;
        endcase
      end
      if (cmd_wr && busy) err_q <= 1'b1;
      // R6: received data byte lands in its lane; dummy bytes are dropped
      if (byte_done && cur_ph == PH_DATA && !dir_q)
        data_q[{k_q, 3'b000} +: 8] <= rx_byte;
      if (take) begin
        if (start) begin
          dir_q  <= f_dir;
          keep_q <= f_keep;
          if (!cs_held) begin
            cs_held <= 1'b1;
            cs_n    <= cs_dec;
          end
        end
        k_q <= s_k;
        if (pick_v) begin
          busy   <= 1'b1;
          cur_ph <= pick_ph;
          a_rem  <= (pick_ph == PH_ADDR) ? s_a - 2'd1 : s_a;
          d_rem  <= (pick_ph == PH_DUM)  ? s_d - 4'd1 : s_d;
          n_rem  <= (pick_ph == PH_DATA) ? s_n - 3'd1 : s_n;
        end else begin
          busy <= 1'b0;
          if (!(start ? f_keep : keep_q)) begin
            cs_held <= 1'b0;
            cs_n    <= '1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        AW'(REG_TIME): bus_rdata <= {16'h0, tm_q};
        AW'(REG_ADDR): bus_rdata <= {8'h0, addr_q};
        AW'(REG_DATA): bus_rdata <= data_q;
        AW'(REG_STAT): bus_rdata <= (32'(busy) << ST_PEND_BIT) | (32'(err_q) << ST_ERR_BIT);
        default:       bus_rdata <= '0;
      endcase
    end
  end

  // R7: pending holds until the last bit of the frame
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !byte_done) |=> busy);
  // R8: a command during a frame raises the error flag
  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> err_q);
  // R9: chip select is held for the whole frame
  p_cs_frame_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> cs_held);
  // R12: at most one chip select line is low
  p_one_cs_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R4: dummy bytes drive MOSI low
  p_dummy_low_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cur_ph == PH_DUM && fall_tick) |=> !mosi);
endmodule

// File: tb/sim_sflash_seq.sv
`timescale 1ns/1ps
module sim_sflash_seq;
  logic        clk = 1'b0, rst = 1'b1, we = 1'b0, miso = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi;
  logic [1:0]  cs_n;

  sflash_seq u0 (
    .clk, .rst, .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .sck, .mosi, .miso, .cs_n
  );

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  logic [7:0]  cap [0:31];
  logic [7:0]  sb  [0:31];
  int          nb = 0, sidx = 0, tim_err = 0, per_b = 4, rise_off = 2;
  time         last_fall = 0;
  bit          have_fall = 0;
  logic [1:0]  cs_seen = '0;
  bit          m_held = 0;
  logic [2:0]  m_cs = '0;
  logic [31:0] m_data = '0, m_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model: drives MISO at SCK fall, captures MOSI at SCK rise, times edges
  always @(negedge sck) begin
    if (have_fall && ($time - last_fall) != per_b * 20) tim_err++;
    last_fall = $time;
    have_fall = 1;
    miso <= sb[(sidx >> 3) & 31][7 - (sidx & 7)];
    sidx++;
  end
  always @(posedge sck) begin
    if (have_fall && ($time - last_fall) != rise_off * 20) tim_err++;
    if (nb < 256) cap[nb >> 3] = {cap[nb >> 3][6:0], mosi};
    nb++;
  end
  always @(negedge clk) cs_seen |= ~cs_n;

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic set_time(input int p, input int r, input int f);
    wr(3'd0, {16'h0, 4'(f), 4'(r), 4'h0, 4'(p)});
    per_b = (p < 2) ? 2 : p;
    rise_off = r - f;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin rd(3'd4, s); n++; end while (s[22] && n < 100000);
  endtask

  function automatic logic [31:0] mk(input int op, input int wrb, input int cnt, input int keep,
                                     input int dum, input int alen, input int cs);
    return 32'(op & 255) | (32'(wrb & 1) << 8) | (32'(cnt & 7) << 9) | (32'(keep & 1) << 15)
         | (32'(dum & 15) << 16) | (32'(alen & 7) << 20) | (32'(cs & 7) << 24);
  endfunction

  task automatic run_cmd(input logic [31:0] c, input bit poke);
    int alen, cnt, dum, nby, bad, fi;
    logic [7:0]  eb [0:31];
    logic [31:0] s, d;
    logic [1:0]  ecs;
    bit dir, keep;
    alen = (c[22:20] > 3) ? 3 : int'(c[22:20]);
    cnt  = (c[11:9] > 4) ? 4 : int'(c[11:9]);
    dum  = int'(c[19:16]);
    dir  = c[8];
    keep = c[15];
    nby  = 0;
    if (!m_held) begin eb[nby] = c[7:0]; nby++; end
    for (int i = alen - 1; i >= 0; i--) begin eb[nby] = m_addr[8*i +: 8]; nby++; end
    for (int i = 0; i < dum; i++) begin eb[nby] = 8'h00; nby++; end
    for (int i = 0; i < cnt; i++) begin eb[nby] = dir ? m_data[8*i +: 8] : 8'h00; nby++; end
    for (int i = 0; i < 32; i++) sb[i] = 8'($urandom);
    nb = 0; sidx = 0; have_fall = 0; tim_err = 0; cs_seen = '0;
    wr(3'd3, c);
    if (poke) begin
      rd(3'd4, s);
      chk(s[22] == 1'b1, "R7 pending after start", s, 32'h0040_0000);
      wr(3'd3, mk(8'h03, 1, 0, 0, 0, 0, 0));
      rd(3'd4, s);
      chk(s[29] == 1'b1, "R8 error on command while pending", s, 32'h2040_0000);
    end
    wait_idle();
    bad = 0; fi = -1;
    for (int i = 0; i < nby; i++)
      if (cap[i] !== eb[i]) begin bad++; if (fi < 0) fi = i; end
    chk(nb == 8 * nby, "R2 bit count of frame", 64'(nb), 64'(8 * nby));
    if (nby > 0)
      chk(bad == 0, "R2/R3/R4/R5 mosi byte stream", (fi < 0) ? 64'h0 : 64'(cap[fi]),
          (fi < 0) ? 64'h0 : 64'(eb[fi]));
    chk(tim_err == 0, "R11 sck edge spacing", 64'(tim_err), 64'h0);
    if (!dir)
      for (int k = 0; k < cnt; k++) m_data[8*k +: 8] = sb[nby - cnt + k];
    rd(3'd2, d);
    chk(d === m_data, dir ? "R5 data register unchanged by write" : "R6/R4 read data lanes",
        64'(d), 64'(m_data));
    if (!m_held) begin m_held = 1; m_cs = c[26:24]; end
    if (!keep) m_held = 0;
    ecs = 2'b11;
    if (m_held && m_cs < 2) ecs[m_cs[0]] = 1'b0;
    chk(cs_n === ecs, keep ? "R9 chip select held" : "R10 chip select released",
        64'(cs_n), 64'(ecs));
  endtask

  task automatic set_addr(input logic [31:0] v);
    wr(3'd1, v); m_addr = {8'h0, v[23:0]};
  endtask
  task automatic set_data(input logic [31:0] v);
    wr(3'd2, v); m_data = v;
  endtask

  bit finished = 0;

  initial begin
    logic [31:0] s;
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) begin sb[i] = 8'h00; cap[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd4, s); chk(s == 32'h0, "R1 status after reset", s, 0);
    chk(cs_n == 2'b11, "R1 cs_n after reset", cs_n, 2'b11);
    chk(sck == 1'b1, "R1 sck idles high (R11)", sck, 1);
    rd(3'd0, s); chk(s == 32'h0204, "R1 timing reset value", s, 32'h0204);
    rd(3'd2, s); chk(s == 32'h0, "R1 data after reset", s, 0);

    // R13 register map
    set_addr(32'hFFFF_FFFF);
    rd(3'd1, s); chk(s == 32'h00FF_FFFF, "R13 address readback 24 bits", s, 32'h00FF_FFFF);
    set_data(32'hCAFE_F00D);
    rd(3'd2, s); chk(s == 32'hCAFE_F00D, "R13 data readback", s, 32'hCAFE_F00D);
    rd(3'd3, s); chk(s == 32'h0, "R13 command reads zero", s, 0);

    set_time(4, 2, 0);
    run_cmd(mk(8'h9F, 0, 0, 0, 0, 0, 0), 0);                 // R2 opcode only
    set_addr(32'h00A1_B2C3);
    run_cmd(mk(8'h0B, 0, 4, 0, 1, 3, 0), 0);                 // R3 R4 R6
    set_data(32'h1122_3344);
    run_cmd(mk(8'h02, 1, 7, 0, 0, 7, 0), 0);                 // R3 R5 clamps
    run_cmd(mk(8'h03, 0, 1, 0, 2, 2, 0), 0);                 // R6 partial read
    set_time(0, 1, 0);                                       // R11 period clamp
    run_cmd(mk(8'h05, 0, 2, 0, 0, 1, 0), 0);
    set_time(5, 3, 1);

    // R9 chained frames under one chip select
    run_cmd(mk(8'h0B, 0, 0, 1, 1, 3, 0), 0);
    run_cmd(mk(8'h77, 0, 4, 1, 0, 0, 1), 0);
    run_cmd(mk(8'h77, 0, 2, 0, 0, 0, 1), 0);

    // R10 release-only command
    run_cmd(mk(8'h06, 0, 0, 1, 0, 0, 0), 0);
    run_cmd(mk(8'h00, 0, 0, 0, 0, 0, 0), 0);

    // R7 R8 pending and error handling
    set_time(6, 4, 1);
    run_cmd(mk(8'hEB, 0, 4, 0, 15, 3, 0), 1);
    wr(3'd4, 32'h0);
    rd(3'd4, s); chk(s[29] == 1'b1, "R8 writing 0 keeps error", s, 32'h2000_0000);
    wr(3'd4, 32'h2000_0000);
    rd(3'd4, s); chk(s == 32'h0, "R8 error cleared by writing 1", s, 0);

    // R12 chip select decode
    set_time(3, 2, 0);
    run_cmd(mk(8'h02, 1, 1, 0, 0, 0, 5), 0);
    chk(cs_seen == 2'b00, "R12 out-of-range select asserts none", cs_seen, 0);
    run_cmd(mk(8'h02, 1, 1, 1, 0, 0, 1), 0);
    chk(cs_seen == 2'b10, "R12 select 1 drives line 1", cs_seen, 2'b10);
    run_cmd(mk(8'h02, 1, 1, 0, 0, 0, 0), 0);
    chk(cs_seen == 2'b10, "R9 select field ignored while held", cs_seen, 2'b10);

    // random commands
    for (int t = 0; t < 30; t++) begin
      int p, f, r;
      p = 2 + int'($urandom % 5);
      f = int'($urandom % (p - 1));
      r = f + 1 + int'($urandom % (p - 1 - f));
      set_time(p, r, f);
      if ($urandom % 2) set_addr($urandom);
      if ($urandom % 2) set_data($urandom);
      run_cmd(mk(int'($urandom % 256), int'($urandom % 2), int'($urandom % 5),
                 int'($urandom % 2), int'($urandom % 4), int'($urandom % 4),
                 int'($urandom % 2)), 0);
    end
    run_cmd(mk(8'h00, 0, 0, 0, 0, 0, 0), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule